// File: doc/BRIEF.md
# Path Overhead Serial Insertion Port

This block gathers the nine path overhead bytes of one transmit channel and builds each of them bit by bit from two sources: a slow serial input paired with a per-bit insert flag, and a parallel word that carries the bytes from whatever source is configured elsewhere. The serial side is timed by a single-cycle bit enable in the system clock domain. This enable stands in for a bit clock near 576 kHz that is locked to the payload rate. One frame spans 72 such enables, which is 125 µs of line time.

A free-running slot counter tracks the position within the frame. The block raises a frame pulse in the enable cycle where the first byte's most significant bit is expected on the serial line. Under each enable, a live insert flag chooses which source supplies that one bit. A single enable input can switch off serial insertion entirely. When the frame's last bit has been taken, the nine merged bytes are presented together with a one-cycle valid strobe. They stay on the output until the next frame completes.

Top module: `poh_ins_port`

## Requirements
- R1: While rst is high, merged_valid is 0, merged_bytes is all zeros and the slot position returns to 0. The first bit enable after reset is slot 0 of a new frame, even when reset arrives in the middle of a frame.
- R2: frame_pulse is high only in a cycle where bit_en is high and the current slot is 0. It is therefore seen exactly once in every 72 bit enables, on the first enable after reset and on every 72nd enable after that.
- R3: Slot s (0..71) of a frame carries bit 7-(s mod 8) of byte s/8, MSB first. Byte 0 (the trace byte) sits in merged_bytes[71:64] and byte 8 in merged_bytes[7:0], so slot s lands in merged_bytes bit 71-s. alt_bytes uses the same bit mapping.
- R4: When ins_enable is 1 and ins_flag is 1 in a slot's enable cycle, the merged bit for that slot equals ser_data.
- R5: When ins_enable is 1 and ins_flag is 0 in a slot's enable cycle, the merged bit equals alt_bytes bit 71-s.
- R6: When ins_enable is 0, every merged bit equals alt_bytes bit 71-s, whatever ins_flag and ser_data are.
- R7: merged_valid is high for exactly the one cycle after the clock edge that takes slot 71. merged_bytes updates only on that edge and holds its value until the next frame completes.
- R8: Cycles with bit_en low do not advance the slot and do not sample ser_data, ins_flag or alt_bytes.
- R9: Only the value of alt_bytes in a slot's own enable cycle counts, and only its bit 71-s. A change to alt_bytes between slots affects only the slots that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle serial bit enable |
| ser_data | input | 1 | Serial overhead data bit |
| ins_flag | input | 1 | Per-bit insert request |
| ins_enable | input | 1 | Global enable for serial insertion |
| alt_bytes | input | 72 | Bytes from the configured source, byte 0 in the top bits |
| frame_pulse | output | 1 | Marks the enable cycle of slot 0 |
| merged_bytes | output | 72 | Nine merged bytes of the last completed frame |
| merged_valid | output | 1 | One-cycle strobe when merged_bytes updates |

## Verification
The assertions assume that bit_en is a clean pulse sampled on the clock, and that enough system cycles separate two frame completions that the valid strobe cannot be seen in two cycles in a row. The frame is 72 enables long, so this holds even when bit_en is high on every cycle. The stimulus changes every input on the falling clock edge only. In frames with idle gaps it drives random values on ser_data, ins_flag and alt_bytes between enables, and the expected bytes are built only from the values present in the enable cycles. Reset is raised both from idle and in the middle of a frame, and the slot counter is left to start from slot 0.

// File: rtl/poh_pkg.sv
package poh_pkg;

    localparam int DEF_BYTE_W    = 8;
    localparam int DEF_NUM_BYTES = 9;

    // one serial sample: data bit plus its insert request
    typedef struct packed {
        logic data;
        logic flag;
    } ser_bit_t;

    typedef enum logic [0:0] {
        SRC_ALT = 1'b0,
        SRC_SER = 1'b1
    } bit_src_e;

    // serial source wins only when globally enabled and flagged for this bit
    function automatic bit_src_e pick_src(input logic ins_en, input logic flag);
        return (ins_en && flag) ? SRC_SER : SRC_ALT;
    endfunction

endpackage

// File: rtl/poh_slot_timer.sv
module poh_slot_timer #(
    parameter int FRAME_BITS = 72,
    parameter int SLOT_W     = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_pulse,
    output logic              last_slot
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (bit_en) begin
            slot <= last_slot ? '0 : slot + 1'b1;
        end
    end

    assign last_slot   = (slot == LAST);
    assign frame_pulse = bit_en && (slot == '0);

    assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
        slot <= LAST);

    assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_en && last_slot) |=> (slot == '0));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(slot));

endmodule

// File: rtl/poh_bit_merge.sv
module poh_bit_merge
    import poh_pkg::*;
#(
    parameter int NUM_BYTES  = DEF_NUM_BYTES,
    parameter int BYTE_W     = DEF_BYTE_W,
    parameter int FRAME_BITS = NUM_BYTES * BYTE_W,
    parameter int SLOT_W     = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_en,
    input  logic [SLOT_W-1:0]     slot,
    input  logic                  last_slot,
    input  ser_bit_t              sample,
    input  logic                  ins_enable,
    input  logic [FRAME_BITS-1:0] alt_vec,
    output logic [FRAME_BITS-1:0] merged_vec,
    output logic                  merged_valid
);

    logic [FRAME_BITS-1:0] work;
    logic [FRAME_BITS-1:0] next_work;
    logic                  sel_bit;
    logic                  alt_bit;
    bit_src_e              src;

    // slot s maps to vector bit FRAME_BITS-1-s (first byte MSB at the top)
    assign alt_bit = alt_vec[(FRAME_BITS-1) - int'(slot)];
    assign src     = pick_src(ins_enable, sample.flag);
    assign sel_bit = (src == SRC_SER) ? sample.data : alt_bit;

    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_bit
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(FRAME_BITS - 1 - i);
        assign next_work[i] = (bit_en && slot == MY_SLOT) ? sel_bit : work[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work         <= '0;
            merged_vec   <= '0;
            merged_valid <= 1'b0;
        end else begin
            merged_valid <= bit_en && last_slot;
            if (bit_en) begin
                work <= next_work;
            end
            if (bit_en && last_slot) begin
                merged_vec <= next_work;
            end
        end
    end

    assert_valid_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        merged_valid |-> $past(bit_en && last_slot));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        merged_valid |=> !merged_valid);

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !merged_valid |-> $stable(merged_vec));

endmodule

// File: rtl/poh_ins_port.sv
module poh_ins_port
    import poh_pkg::*;
#(
    parameter int NUM_BYTES  = DEF_NUM_BYTES,
    parameter int BYTE_W     = DEF_BYTE_W,
    parameter int FRAME_BITS = NUM_BYTES * BYTE_W,
    parameter int SLOT_W     = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bit_en,
    input  logic                  ser_data,
    input  logic                  ins_flag,
    input  logic                  ins_enable,
    input  logic [FRAME_BITS-1:0] alt_bytes,
    output logic                  frame_pulse,
    output logic [FRAME_BITS-1:0] merged_bytes,
    output logic                  merged_valid
);

    logic [SLOT_W-1:0] slot;
    logic              last_slot;
    ser_bit_t          sample;

    assign sample = '{data: ser_data, flag: ins_flag};

    poh_slot_timer #(
        .FRAME_BITS (FRAME_BITS),
        .SLOT_W     (SLOT_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .slot        (slot),
        .frame_pulse (frame_pulse),
        .last_slot   (last_slot)
    );

    poh_bit_merge #(
        .NUM_BYTES  (NUM_BYTES),
        .BYTE_W     (BYTE_W),
        .FRAME_BITS (FRAME_BITS),
        .SLOT_W     (SLOT_W)
    ) u_merge (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .slot         (slot),
        .last_slot    (last_slot),
        .sample       (sample),
        .ins_enable   (ins_enable),
        .alt_vec      (alt_bytes),
        .merged_vec   (merged_bytes),
        .merged_valid (merged_valid)
    );

endmodule

// File: tb/sim_poh_ins_port.sv
module sim_poh_ins_port;

    localparam int CLK_PERIOD = 10;
    localparam int FB         = 72;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst;
    logic          bit_en;
    logic          ser_data;
    logic          ins_flag;
    logic          ins_enable;
    logic [FB-1:0] alt_bytes;
    logic          frame_pulse;
    logic [FB-1:0] merged_bytes;
    logic          merged_valid;

    int            total = 0;
    int            bad   = 0;
    logic [31:0]   lfsr  = 32'h1ACE5EED;

    always #(CLK_PERIOD/2) clk = ~clk;

    poh_ins_port u0 (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .ser_data     (ser_data),
        .ins_flag     (ins_flag),
        .ins_enable   (ins_enable),
        .alt_bytes    (alt_bytes),
        .frame_pulse  (frame_pulse),
        .merged_bytes (merged_bytes),
        .merged_valid (merged_valid)
    );

    task automatic rnd32(output logic [31:0] r);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        r = lfsr;
    endtask

    task automatic rnd72(output logic [FB-1:0] v);
        logic [31:0] a, b, c;
        rnd32(a); rnd32(b); rnd32(c);
        v = {a[7:0], b, c};
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [FB-1:0] act, input logic [FB-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drives random values while bit_en is low
    task automatic idle_garbage();
        logic [31:0]   r;
        logic [FB-1:0] g;
        rnd32(r);
        rnd72(g);
        bit_en    = 1'b0;
        ser_data  = r[3];
        ins_flag  = r[9];
        alt_bytes = g;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        idle_garbage();
        for (int i = 0; i < cycles; i++) @(negedge clk);
        #1;
        check_eq("R1", "valid in reset", FB'(merged_valid), FB'(0));
        check_eq("R1", "bytes in reset", merged_bytes, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one full frame; returns nothing, checks output bytes, valid and pulses
    task automatic run_frame(input string req, input logic en,
                             input logic [FB-1:0] data_v, input logic [FB-1:0] flag_v,
                             input logic [FB-1:0] alt_v, input bit live_alt,
                             input int gap, output logic [FB-1:0] exp);
        int pulses = 0;
        int bad_pulse = 0;
        logic [FB-1:0] prev;
        exp = '0;
        for (int s = 0; s < FB; s++) begin
            int idx = FB - 1 - s;
            @(negedge clk);
            bit_en     = 1'b1;
            ins_enable = en;
            ser_data   = data_v[idx];
            ins_flag   = flag_v[idx];
            if (live_alt) begin
                alt_bytes      = ~alt_v;
                alt_bytes[idx] = alt_v[idx];
            end else begin
                alt_bytes = alt_v;
            end
            exp[idx] = (en && flag_v[idx]) ? data_v[idx] : alt_v[idx];
            #1;
            if (frame_pulse) begin
                pulses++;
                if (s != 0) bad_pulse++;
            end
            if (s != FB - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    idle_garbage();
                    #1;
                    if (frame_pulse) bad_pulse++;
                end
            end
        end
        @(negedge clk);
        idle_garbage();
        #1;
        check_eq("R2", {req, " frame pulse count"}, FB'(pulses), FB'(1));
        check_eq("R2", {req, " misplaced pulses"}, FB'(bad_pulse), FB'(0));
        check_eq("R7", {req, " valid after last bit"}, FB'(merged_valid), FB'(1));
        check_eq(req, "merged bytes", merged_bytes, exp);
        prev = merged_bytes;
        @(negedge clk);
        idle_garbage();
        #1;
        check_eq("R7", {req, " valid drops"}, FB'(merged_valid), FB'(0));
        check_eq("R7", {req, " bytes held"}, merged_bytes, prev);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_garbage();
        ins_enable = 1'b0;
        do_reset(3);
        #1;
        check_eq("R2", "no pulse while idle", FB'(frame_pulse), FB'(0));
        check_eq("R1", "valid after release", FB'(merged_valid), FB'(0));
    endtask

    task automatic t_all_serial();
        logic [FB-1:0] d, a, e;
        rnd72(d); rnd72(a);
        run_frame("R4", 1'b1, d, '1, a, 1'b0, 0, e);
        check_eq("R4", "all bits serial", e, d);
    endtask

    task automatic t_all_alt();
        logic [FB-1:0] d, a, e;
        rnd72(d); rnd72(a);
        run_frame("R5", 1'b1, d, '0, a, 1'b0, 0, e);
        check_eq("R5", "all bits alternative", e, a);
    endtask

    task automatic t_disabled();
        logic [FB-1:0] a, e;
        rnd72(a);
        run_frame("R6", 1'b0, ~a, '1, a, 1'b0, 1, e);
        check_eq("R6", "disabled keeps alternative", e, a);
    endtask

    task automatic t_byte_order();
        logic [FB-1:0] d, a, e;
        d = '0;
        for (int k = 0; k < 9; k++) d[FB-1-8*k -: 8] = 8'hA0 + 8'(k);
        rnd72(a);
        run_frame("R3", 1'b1, d, '1, a, 1'b0, 0, e);
        for (int k = 0; k < 9; k++) begin
            check_eq("R3", $sformatf("byte %0d position", k),
                     FB'(merged_bytes[FB-1-8*k -: 8]), FB'(8'hA0 + 8'(k)));
        end
    endtask

    task automatic t_mixed_gaps();
        logic [FB-1:0] d, f, a, e;
        rnd72(d); rnd72(f); rnd72(a);
        run_frame("R8", 1'b1, d, f, a, 1'b0, 3, e);
        check_eq("R4", "mixed serial bits", e & f, d & f);
        check_eq("R5", "mixed alternative bits", e & ~f, a & ~f);
    endtask

    task automatic t_live_alt();
        logic [FB-1:0] d, f, a, e;
        rnd72(d); rnd72(f); rnd72(a);
        run_frame("R9", 1'b1, d, f, a, 1'b1, 1, e);
    endtask

    task automatic t_midframe_reset();
        logic [FB-1:0] d, a, e;
        for (int s = 0; s < 20; s++) begin
            @(negedge clk);
            bit_en   = 1'b1;
            ser_data = s[0];
            ins_flag = 1'b1;
        end
        do_reset(2);
        rnd72(d); rnd72(a);
        run_frame("R1", 1'b1, d, '1, a, 1'b0, 0, e);
    endtask

    task automatic t_back_to_back();
        logic [FB-1:0] d, f, a, e;
        for (int n = 0; n < 2; n++) begin
            rnd72(d); rnd72(f); rnd72(a);
            run_frame("R2", 1'b1, d, f, a, 1'b0, 0, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        bit_en     = 1'b0;
        ser_data   = 1'b0;
        ins_flag   = 1'b0;
        ins_enable = 1'b0;
        alt_bytes  = '0;
        t_reset();
        t_all_serial();
        t_all_alt();
        t_disabled();
        t_byte_order();
        t_mixed_gaps();
        t_live_alt();
        t_midframe_reset();
        t_back_to_back();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule